// File: doc/BRIEF.md
# Sensor Frame Sync and Exposure Controller

This block sets the line and frame timing of an image sensor and runs the exposure sequence for a single captured frame. In master mode a pair of counters produces the line and frame sync waveforms and drives them out with their output enables high. In slave mode the output enables drop, so the pads can act as inputs. The externally supplied line sync then passes through a clock-domain synchronizer. The external frame sync is taken in only on a rising edge of that already-synchronized line sync. The rest of the chip follows one selected pair of timing references, `line_sync_o` and `frame_sync_o`.

The exposure sequence is driven by an external level input, `frex_i`. A high level starts a precharge phase of fixed length. If the level is still high when precharge ends, the block integrates for as long as it stays high. When it falls, a one-cycle pulse starts line-by-line readout. A pulse too short to cover the whole precharge ends the sequence with a one-cycle invalid flag instead. A power-down input clears every counter and the sequencer while it is held. A register write selects the mode, and a soft reset request returns it to master.

Top module: `fsync_expo_ctrl`

## Requirements
- R1: After `rst`, or in the cycle after a cycle with `soft_rst_i` high, the block is in master mode with `hsync_oe` and `vsync_oe` both 1. A cycle with `cfg_wr_i` high loads `cfg_slave_i` into the mode bit. A 1 means slave mode, and both enables are then 0 from the next cycle on. `soft_rst_i` wins over `cfg_wr_i`.
- R2: The line counter starts at 0 after reset or power-down and runs through LINE_LEN cycles per line. `hsync_o` is 1 in the last HS_W cycles of each line. `vsync_o` is 1 throughout the last VS_LINES lines of each FRAME_LINES-line frame.
- R3: In slave mode, `line_sync_o` equals `ext_hsync_i` delayed by SYNC_STAGES clock cycles.
- R4: In slave mode, `frame_sync_o` changes only in the cycle after `line_sync_o` rises. It then takes the value of `ext_vsync_i` from SYNC_STAGES+1 cycles earlier, and otherwise holds.
- R5: In master mode, `line_sync_o` equals `hsync_o` and `frame_sync_o` equals `vsync_o`.
- R6: `frex_i` sampled high while the sequencer is idle starts precharge. `precharge_o` is then 1 for PRECH_CYC cycles, beginning in the next cycle.
- R7: Suppose `frex_i` stays high for K > PRECH_CYC consecutive samples. Then `integrate_o` is 1 for K-PRECH_CYC cycles after precharge, and `readout_start_o` pulses for exactly one cycle right after that.
- R8: Suppose `frex_i` stays high for K <= PRECH_CYC samples. Then precharge lasts K cycles and `expo_invalid_o` pulses for one cycle, with no integration and no readout pulse.
- R9: Any cycle after one with `pwdn_i` high shows `precharge_o`, `integrate_o`, `readout_start_o`, `expo_invalid_o`, `hsync_o` and `vsync_o` all 0. While `pwdn_i` is held, a high `frex_i` starts nothing.
- R10: `precharge_o` and `integrate_o` are never 1 together. Integration begins only directly after a precharge cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr_i | input | 1 | Write strobe for the mode bit |
| cfg_slave_i | input | 1 | Mode value written (1 = slave) |
| soft_rst_i | input | 1 | Register-interface reset request |
| pwdn_i | input | 1 | Power-down, clears counters and sequencer |
| ext_hsync_i | input | 1 | External line sync, active high |
| ext_vsync_i | input | 1 | External frame sync, active high |
| frex_i | input | 1 | Exposure request level |
| hsync_o | output | 1 | Generated line sync drive |
| hsync_oe | output | 1 | Line sync pad output enable |
| vsync_o | output | 1 | Generated frame sync drive |
| vsync_oe | output | 1 | Frame sync pad output enable |
| line_sync_o | output | 1 | Selected line timing reference |
| frame_sync_o | output | 1 | Selected frame timing reference |
| precharge_o | output | 1 | Precharge phase active |
| integrate_o | output | 1 | Integration phase active |
| readout_start_o | output | 1 | One-cycle readout start pulse |
| expo_invalid_o | output | 1 | One-cycle short-exposure flag |

## Verification
The properties assume that `frex_i`, `pwdn_i`, `cfg_wr_i` and `soft_rst_i` are synchronous to `clk`. They also assume that power-down and mode are steady for a few cycles around any frame sync change they judge. The external syncs may be fully asynchronous in a real system. The bench nevertheless changes them only at the falling clock edge, so the synchronizer delay is an exact cycle count. The random phases keep the mode fixed and power-down low. The directed steps switch the mode or power down only between those phases.

// File: rtl/fsx_pkg.sv
package fsx_pkg;

    typedef enum logic [1:0] {
        EX_IDLE  = 2'd0,
        EX_PRECH = 2'd1,
        EX_INTEG = 2'd2
    } expo_state_t;

    typedef struct packed {
        logic line;
        logic frame;
    } sync_pair_t;

    typedef struct packed {
        logic precharge;
        logic integrate;
        logic readout_start;
        logic invalid;
    } expo_flags_t;

    function automatic int unsigned cnt_w(int unsigned n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/fsx_master_timing.sv
module fsx_master_timing
    import fsx_pkg::*;
#(
    parameter int unsigned LINE_LEN    = 16,
    parameter int unsigned HS_W        = 3,
    parameter int unsigned FRAME_LINES = 6,
    parameter int unsigned VS_LINES    = 1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       clr,
    output sync_pair_t gen
);
    localparam int unsigned HW = cnt_w(LINE_LEN);
    localparam int unsigned VW = cnt_w(FRAME_LINES);
    localparam logic [HW-1:0] H_LAST  = HW'(LINE_LEN - 1);
    localparam logic [VW-1:0] V_LAST  = VW'(FRAME_LINES - 1);
    localparam logic [HW-1:0] H_START = HW'(LINE_LEN - HS_W);
    localparam logic [VW-1:0] V_START = VW'(FRAME_LINES - VS_LINES);

    logic [HW-1:0] h_cnt;
    logic [VW-1:0] v_cnt;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            h_cnt <= '0;
            v_cnt <= '0;
        end else if (h_cnt == H_LAST) begin
            h_cnt <= '0;
            v_cnt <= (v_cnt == V_LAST) ? '0 : v_cnt + 1'b1;
        end else begin
            h_cnt <= h_cnt + 1'b1;
        end
    end

    always_comb begin
        gen.line  = (h_cnt >= H_START);
        gen.frame = (v_cnt >= V_START);
    end

endmodule

// File: rtl/fsx_slave_sync.sv
module fsx_slave_sync
    import fsx_pkg::*;
#(
    parameter int unsigned STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       clr,
    input  logic       ext_hs,
    input  logic       ext_vs,
    output sync_pair_t synced
);
    logic [STAGES-1:0] hs_chain;
    logic [STAGES-1:0] vs_chain;
    logic              hs_prev;
    logic              vs_hold;

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst || clr) begin
                    hs_chain[0] <= 1'b0;
                    vs_chain[0] <= 1'b0;
                end else begin
                    hs_chain[0] <= ext_hs;
                    vs_chain[0] <= ext_vs;
                end
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst || clr) begin
                    hs_chain[s] <= 1'b0;
                    vs_chain[s] <= 1'b0;
                end else begin
                    hs_chain[s] <= hs_chain[s-1];
                    vs_chain[s] <= vs_chain[s-1];
                end
            end
        end
    end

    // Frame sync is qualified by a rising edge of the synchronized line sync.
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            hs_prev <= 1'b0;
            vs_hold <= 1'b0;
        end else begin
            hs_prev <= hs_chain[STAGES-1];
            if (hs_chain[STAGES-1] && !hs_prev) begin
                vs_hold <= vs_chain[STAGES-1];
            end
        end
    end

    always_comb begin
        synced.line  = hs_chain[STAGES-1];
        synced.frame = vs_hold;
    end

endmodule

// File: rtl/fsx_expo_fsm.sv
module fsx_expo_fsm
    import fsx_pkg::*;
#(
    parameter int unsigned PRECH_CYC = 5
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        clr,
    input  logic        frex,
    output expo_flags_t flags
);
    localparam int unsigned PW = cnt_w(PRECH_CYC);
    localparam logic [PW-1:0] P_LAST = PW'(PRECH_CYC - 1);

    expo_state_t   state;
    logic [PW-1:0] cnt;
    logic          ro_q;
    logic          inv_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            state <= EX_IDLE;
            cnt   <= '0;
            ro_q  <= 1'b0;
            inv_q <= 1'b0;
        end else begin
            ro_q  <= 1'b0;
            inv_q <= 1'b0;
            unique case (state)
                EX_IDLE: begin
                    cnt <= '0;
                    if (frex) begin
                        state <= EX_PRECH;
                    end
                end
                EX_PRECH: begin
                    if (!frex) begin
                        state <= EX_IDLE;
                        inv_q <= 1'b1;
                    end else if (cnt == P_LAST) begin
                        state <= EX_INTEG;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                EX_INTEG: begin
                    if (!frex) begin
                        state <= EX_IDLE;
                        ro_q  <= 1'b1;
                    end
                end
                default: state <= EX_IDLE;
            endcase
        end
    end

    always_comb begin
        flags.precharge     = (state == EX_PRECH);
        flags.integrate     = (state == EX_INTEG);
        flags.readout_start = ro_q;
        flags.invalid       = inv_q;
    end

endmodule

// File: rtl/fsync_expo_ctrl.sv
module fsync_expo_ctrl
    import fsx_pkg::*;
#(
    parameter int unsigned LINE_LEN    = 16,
    parameter int unsigned HS_W        = 3,
    parameter int unsigned FRAME_LINES = 6,
    parameter int unsigned VS_LINES    = 1,
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned PRECH_CYC   = 5
) (
    input  logic clk,
    input  logic rst,
    input  logic cfg_wr_i,
    input  logic cfg_slave_i,
    input  logic soft_rst_i,
    input  logic pwdn_i,
    input  logic ext_hsync_i,
    input  logic ext_vsync_i,
    input  logic frex_i,
    output logic hsync_o,
    output logic hsync_oe,
    output logic vsync_o,
    output logic vsync_oe,
    output logic line_sync_o,
    output logic frame_sync_o,
    output logic precharge_o,
    output logic integrate_o,
    output logic readout_start_o,
    output logic expo_invalid_o
);
    logic        slave_q;
    sync_pair_t  gen_sync;
    sync_pair_t  ext_sync;
    sync_pair_t  sel_sync;
    expo_flags_t expo;

    always_ff @(posedge clk) begin
        if (rst || soft_rst_i) begin
            slave_q <= 1'b0;
        end else if (cfg_wr_i) begin
            slave_q <= cfg_slave_i;
        end
    end

    fsx_master_timing #(
        .LINE_LEN    (LINE_LEN),
        .HS_W        (HS_W),
        .FRAME_LINES (FRAME_LINES),
        .VS_LINES    (VS_LINES)
    ) u_master (
        .clk (clk),
        .rst (rst),
        .clr (pwdn_i),
        .gen (gen_sync)
    );

    fsx_slave_sync #(
        .STAGES (SYNC_STAGES)
    ) u_slave (
        .clk    (clk),
        .rst    (rst),
        .clr    (pwdn_i),
        .ext_hs (ext_hsync_i),
        .ext_vs (ext_vsync_i),
        .synced (ext_sync)
    );

    fsx_expo_fsm #(
        .PRECH_CYC (PRECH_CYC)
    ) u_expo (
        .clk   (clk),
        .rst   (rst),
        .clr   (pwdn_i),
        .frex  (frex_i),
        .flags (expo)
    );

    always_comb begin
        sel_sync        = slave_q ? ext_sync : gen_sync;
        hsync_o         = gen_sync.line;
        vsync_o         = gen_sync.frame;
        hsync_oe        = !slave_q;
        vsync_oe        = !slave_q;
        line_sync_o     = sel_sync.line;
        frame_sync_o    = sel_sync.frame;
        precharge_o     = expo.precharge;
        integrate_o     = expo.integrate;
        readout_start_o = expo.readout_start;
        expo_invalid_o  = expo.invalid;
    end

endmodule

// File: rtl/fsync_expo_ctrl_chk.sv
module fsync_expo_ctrl_chk (
    input logic clk,
    input logic rst,
    input logic soft_rst_i,
    input logic pwdn_i,
    input logic frex_i,
    input logic slave_q,
    input logic hsync_o,
    input logic vsync_o,
    input logic hsync_oe,
    input logic vsync_oe,
    input logic line_sync_o,
    input logic frame_sync_o,
    input logic precharge_o,
    input logic integrate_o,
    input logic readout_start_o,
    input logic expo_invalid_o
);
    // R1
    soft_rst_master_chk: assert property (@(posedge clk) disable iff (rst)
        $past(soft_rst_i) |-> (hsync_oe && vsync_oe));

    // R4
    frame_follows_line_edge_chk: assert property (@(posedge clk) disable iff (rst)
        (slave_q && $past(slave_q) && $past(slave_q, 2) &&
         !pwdn_i && !$past(pwdn_i) && !$past(pwdn_i, 2) &&
         (frame_sync_o != $past(frame_sync_o)))
        |-> ($past(line_sync_o) && !$past(line_sync_o, 2)));

    // R7
    readout_after_integ_chk: assert property (@(posedge clk) disable iff (rst)
        readout_start_o |-> ($past(integrate_o) && !$past(frex_i)));

    // R8
    invalid_after_prech_chk: assert property (@(posedge clk) disable iff (rst)
        expo_invalid_o |-> ($past(precharge_o) && !$past(frex_i) && !integrate_o));

    // R9
    pwdn_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        $past(pwdn_i) |-> !(precharge_o || integrate_o || readout_start_o ||
                            expo_invalid_o || hsync_o || vsync_o));

    // R10
    phase_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({precharge_o, integrate_o}));

    // R10
    integ_entry_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(integrate_o) |-> $past(precharge_o));

endmodule

bind fsync_expo_ctrl fsync_expo_ctrl_chk i_chk (
    .clk             (clk),
    .rst             (rst),
    .soft_rst_i      (soft_rst_i),
    .pwdn_i          (pwdn_i),
    .frex_i          (frex_i),
    .slave_q         (slave_q),
    .hsync_o         (hsync_o),
    .vsync_o         (vsync_o),
    .hsync_oe        (hsync_oe),
    .vsync_oe        (vsync_oe),
    .line_sync_o     (line_sync_o),
    .frame_sync_o    (frame_sync_o),
    .precharge_o     (precharge_o),
    .integrate_o     (integrate_o),
    .readout_start_o (readout_start_o),
    .expo_invalid_o  (expo_invalid_o)
);

// File: tb/test_fsync_expo_ctrl.sv
module test_fsync_expo_ctrl;

    localparam int LINE_LEN    = 16;
    localparam int HS_W        = 3;
    localparam int FRAME_LINES = 6;
    localparam int VS_LINES    = 1;
    localparam int SYNC_STAGES = 2;
    localparam int PRECH_CYC   = 5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cfg_wr_i = 1'b0, cfg_slave_i = 1'b0, soft_rst_i = 1'b0, pwdn_i = 1'b0;
    logic ext_hsync_i = 1'b0, ext_vsync_i = 1'b0, frex_i = 1'b0;
    logic hsync_o, hsync_oe, vsync_o, vsync_oe, line_sync_o, frame_sync_o;
    logic precharge_o, integrate_o, readout_start_o, expo_invalid_o;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    fsync_expo_ctrl #(
        .LINE_LEN(LINE_LEN), .HS_W(HS_W), .FRAME_LINES(FRAME_LINES),
        .VS_LINES(VS_LINES), .SYNC_STAGES(SYNC_STAGES), .PRECH_CYC(PRECH_CYC)
    ) i_fsync_expo_ctrl (
        .clk(clk), .rst(rst), .cfg_wr_i(cfg_wr_i), .cfg_slave_i(cfg_slave_i),
        .soft_rst_i(soft_rst_i), .pwdn_i(pwdn_i), .ext_hsync_i(ext_hsync_i),
        .ext_vsync_i(ext_vsync_i), .frex_i(frex_i), .hsync_o(hsync_o),
        .hsync_oe(hsync_oe), .vsync_o(vsync_o), .vsync_oe(vsync_oe),
        .line_sync_o(line_sync_o), .frame_sync_o(frame_sync_o),
        .precharge_o(precharge_o), .integrate_o(integrate_o),
        .readout_start_o(readout_start_o), .expo_invalid_o(expo_invalid_o)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    function automatic int exp_hs(input int k);
        return ((k % LINE_LEN) >= LINE_LEN - HS_W) ? 1 : 0;
    endfunction

    function automatic int exp_vs(input int k);
        return (((k / LINE_LEN) % FRAME_LINES) >= FRAME_LINES - VS_LINES) ? 1 : 0;
    endfunction

    function automatic int exp_prech(input int k);
        return (k < PRECH_CYC) ? k : PRECH_CYC;
    endfunction

    function automatic int exp_integ(input int k);
        return (k > PRECH_CYC) ? k - PRECH_CYC : 0;
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    always @(posedge clk) cyc <= cyc + 1;

    initial begin
        wait (cyc > 100000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual %0d expected below 100000 cycles", cyc);
        finish_run();
    end

    // Master timing checked from k = 0 at the negedge where counting restarts (R2, R5).
    task automatic master_sweep(input string tag);
        for (int k = 0; k < 2 * LINE_LEN * FRAME_LINES; k++) begin
            if (k != 0) @(negedge clk);
            check({"R2 hsync ", tag}, int'(hsync_o), exp_hs(k));
            check({"R2 vsync ", tag}, int'(vsync_o), exp_vs(k));
            check("R5 line ref", int'(line_sync_o), int'(hsync_o));
            check("R5 frame ref", int'(frame_sync_o), int'(vsync_o));
        end
    endtask

    // One exposure request of K samples, counts compared per R6/R7/R8.
    task automatic expo_pulse(input int k);
        int np = 0, ni = 0, nr = 0, nv = 0;
        @(negedge clk);
        frex_i = 1'b1;
        for (int i = 1; i <= k + 3; i++) begin
            @(negedge clk);
            if (i == 1) check("R6 precharge starts", int'(precharge_o), 1);
            np += int'(precharge_o);
            ni += int'(integrate_o);
            nr += int'(readout_start_o);
            nv += int'(expo_invalid_o);
            if (i == k) frex_i = 1'b0;
        end
        check("R6 precharge length", np, exp_prech(k));
        check("R7 integrate length", ni, exp_integ(k));
        check("R7 readout pulses", nr, (k > PRECH_CYC) ? 1 : 0);
        check("R8 invalid pulses", nv, (k > PRECH_CYC) ? 0 : 1);
    endtask

    initial begin
        void'($urandom(32'h1234_5A5A));
        repeat (3) @(negedge clk);
        check("R1 reset oe", int'(hsync_oe), 1);
        check("R1 reset oe v", int'(vsync_oe), 1);
        check("R9 reset idle", int'(precharge_o | integrate_o | readout_start_o | expo_invalid_o), 0);
        rst = 1'b0;
        master_sweep("after reset");

        // Exposure: directed boundaries then random widths (R6, R7, R8)
        expo_pulse(1);
        expo_pulse(PRECH_CYC);
        expo_pulse(PRECH_CYC + 1);
        expo_pulse(PRECH_CYC + 7);
        for (int n = 0; n < 30; n++) expo_pulse(1 + int'($urandom % 14));

        // Power-down (R9)
        @(negedge clk);
        frex_i = 1'b1;
        repeat (PRECH_CYC + 2) @(negedge clk);
        pwdn_i = 1'b1;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            check("R9 expo quiet", int'(precharge_o | integrate_o | readout_start_o | expo_invalid_o), 0);
            check("R9 sync quiet", int'(hsync_o | vsync_o), 0);
        end
        frex_i = 1'b0;
        pwdn_i = 1'b0;
        master_sweep("after pwdn");

        // Mode register (R1)
        @(negedge clk);
        cfg_wr_i = 1'b1; cfg_slave_i = 1'b1;
        @(negedge clk);
        cfg_wr_i = 1'b0;
        check("R1 slave oe", int'(hsync_oe | vsync_oe), 0);
        soft_rst_i = 1'b1; cfg_wr_i = 1'b1;
        @(negedge clk);
        soft_rst_i = 1'b0; cfg_wr_i = 1'b0;
        check("R1 soft reset oe", int'(hsync_oe & vsync_oe), 1);
        cfg_wr_i = 1'b1; cfg_slave_i = 1'b1;
        @(negedge clk);
        cfg_wr_i = 1'b0;
        check("R1 slave again", int'(hsync_oe), 0);

        // Slave sync with a cycle model (R3, R4)
        begin
            logic hs_d [1:4];
            logic vs_d [1:4];
            logic ef;
            ext_hsync_i = 1'b0; ext_vsync_i = 1'b0;
            repeat (6) @(negedge clk);
            check("R4 frame idle", int'(frame_sync_o), 0);
            for (int j = 1; j <= 4; j++) begin hs_d[j] = 1'b0; vs_d[j] = 1'b0; end
            ef = 1'b0;
            for (int t = 0; t < 600; t++) begin
                @(negedge clk);
                if (hs_d[3] && !hs_d[4]) ef = vs_d[3];
                check("R3 line delay", int'(line_sync_o), int'(hs_d[2]));
                check("R4 frame latch", int'(frame_sync_o), int'(ef));
                if (($urandom % 4) == 0) ext_hsync_i = ~ext_hsync_i;
                if (($urandom % 9) == 0) ext_vsync_i = ~ext_vsync_i;
                for (int j = 4; j > 1; j--) begin hs_d[j] = hs_d[j-1]; vs_d[j] = vs_d[j-1]; end
                hs_d[1] = ext_hsync_i;
                vs_d[1] = ext_vsync_i;
            end
        end
        finish_run();
    end

endmodule